// File: doc/BRIEF.md
# Chained-Block DMA Channel

This block holds the programmable state of a single DMA channel and sequences it through a series of blocks. Software reaches it over a small register bus with single-cycle writes and combinational reads. The channel keeps a 24-bit device address counter and a 24-bit remaining-length counter. Both counters move once for every one-cycle `xfer_done` strobe that the bus engine outside the block raises. The bus engine, channel arbitration and transfer timing are not part of this block.

When the parameter `CHAIN` is set, software can stage the start address and length of the next block in shadow registers and mark them valid. When the current block ends, the channel loads the shadow values and carries on without a gap. If no valid successor is staged, the channel stops and flags an overrun. A mode bit selects auto-initialise operation instead: the shadow values are reloaded at every block end whether or not they are marked valid. The terminal-count and overrun flags are sticky and cleared by writing 1. Each flag has an interrupt enable and a one-cycle interrupt pulse.

Register map, selected by `bus_addr`:

| Offset | Register | Contents |
|---|---|---|
| 0 | control | bit 0 enable, bit 1 valid |
| 1 | status | bit 0 TC, bit 2 OVR, bit 3 active, bit 4 TC interrupt enable, bit 6 OVR interrupt enable |
| 2 | mode | bit 0 step enable, bit 1 count down, bit 2 auto-initialise |
| 3 | address counter | bits 23:0 |
| 4 | length counter | bits 23:0 |
| 5 | next address | bits 23:0 |
| 6 | next length | bits 23:0 |
| 7 | none | reads zero |

Top module: `dma_chain_chan`

## Requirements
- R1: Offsets 3, 4, 5 and 6 store only bits 23:0 of a write. Bits 31:24 of these registers always read as zero. Offset 7 reads as zero.
- R2: On each accepted strobe, the address counter behaves as follows. It holds its value when mode bit 0 is 0. When mode bit 0 is 1, it adds 1 if mode bit 1 is 0 and subtracts 1 if mode bit 1 is 1. It wraps modulo 2^24.
- R3: Each accepted strobe decrements the length counter by 1. The strobe that brings it from 1 to 0 is the block end. At a block end, status bit 0 (TC) is set. If status bit 4 is 1, `irq_tc` is high in the cycle after that strobe.
- R4: At a block end with control bit 1 (valid) equal to 1 and mode bit 2 equal to 0, four things happen. The address counter takes the offset 5 value and the length counter takes the offset 6 value. Valid clears to 0, and enable stays at 1.
- R5: At a block end with valid equal to 0 and mode bit 2 equal to 0, enable clears to 0 and status bit 2 (OVR) is set. If status bit 6 is 1, `irq_ovr` is high in the cycle after that strobe.
- R6: When mode bit 2 (auto-initialise) is 1, every block end reloads both counters from offsets 5 and 6, whatever the value of valid. In this case OVR is not set, valid is left unchanged and enable stays at 1.
- R7: Status bit 3 and the output `chan_active` both equal enable AND (length counter not zero). Writing to status bit 3 has no effect.
- R8: Writing status with bit 0 or bit 2 equal to 1 clears TC or OVR respectively, each independently. Writing 0 to either bit leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: A strobe while `chan_active` is 0 changes neither counter nor any flag.
- R10: Synchronous reset clears every register to zero, so all offsets read 0 and both interrupts are low.
- R11: A bus write to a counter or a shadow register in the same cycle as an accepted strobe wins over the counter update.
- R12: Interrupt outputs are registered pulses. Each is high for exactly one cycle per event, and that is the same cycle in which the matching flag first reads as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| xfer_done | input | 1 | One-cycle strobe: one transfer completed |
| chan_active | output | 1 | Channel enabled with nonzero remaining length |
| irq_tc | output | 1 | Terminal-count interrupt pulse |
| irq_ovr | output | 1 | Overrun interrupt pulse |

## Verification
Two events can land in the same cycle: the final strobe of a block, and a software write to status that clears the flag that strobe sets. The bench provokes this with a status write of 1s issued together with the last strobe, and expects TC and OVR to read set afterwards. A second collision, a counter write together with a strobe, must leave the written value in place. A cycle-by-cycle reference model compares every read, interrupt and activity output. This covers directed sequences and a pseudo-random mix of writes and strobes.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;

    localparam int REG_W = 32;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_MODE  = 3'd2,
        SEL_ADDR  = 3'd3,
        SEL_LEN   = 3'd4,
        SEL_NADDR = 3'd5,
        SEL_NLEN  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic auto_init;
        logic dir_down;
        logic step_en;
    } mode_t;

    typedef struct packed {
        logic valid;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic ovr_ie;
        logic tc_ie;
        logic ovr;
        logic tc;
    } stat_t;

    function automatic logic [REG_W-1:0] pack_stat(stat_t s, logic active);
        logic [REG_W-1:0] v;
        v    = '0;
        v[0] = s.tc;
        v[2] = s.ovr;
        v[3] = active;
        v[4] = s.tc_ie;
        v[6] = s.ovr_ie;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c);
        return {{(REG_W-2){1'b0}}, c.valid, c.enable};
    endfunction

    function automatic logic [REG_W-1:0] pack_mode(mode_t m);
        return {{(REG_W-3){1'b0}}, m.auto_init, m.dir_down, m.step_en};
    endfunction

endpackage

// File: rtl/dmac_counters.sv
`timescale 1ns/1ps
module dmac_counters
    import dmac_pkg::*;
#(
    parameter int AW    = 24,
    parameter bit CHAIN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          reload,
    input  mode_t         mode,
    input  logic          wr_addr,
    input  logic          wr_len,
    input  logic          wr_naddr,
    input  logic          wr_nlen,
    input  logic [AW-1:0] wval,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] len_q,
    output logic [AW-1:0] naddr_q,
    output logic [AW-1:0] nlen_q,
    output logic          last
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] addr_stepped;

    assign last = step && (len_q == ONE);

    always_comb begin
        addr_stepped = addr_q;
        if (mode.step_en)
            addr_stepped = mode.dir_down ? addr_q - ONE : addr_q + ONE;
    end

    generate
        if (CHAIN) begin : g_shadow
            logic [AW-1:0] na_r, nl_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    na_r <= '0;
                    nl_r <= '0;
                end else begin
                    if (wr_naddr) na_r <= wval;
                    if (wr_nlen)  nl_r <= wval;
                end
            end
            assign naddr_q = na_r;
            assign nlen_q  = nl_r;
        end else begin : g_no_shadow
            assign naddr_q = '0;
            assign nlen_q  = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            len_q  <= '0;
        end else begin
            if (wr_addr)     addr_q <= wval;
            else if (reload) addr_q <= naddr_q;
            else if (step)   addr_q <= addr_stepped;

            if (wr_len)      len_q <= wval;
            else if (reload) len_q <= nlen_q;
            else if (step)   len_q <= len_q - ONE;
        end
    end

    a_r3_len_dec: assert property (@(posedge clk) disable iff (rst)
        (step && !reload && !wr_len) |=> (len_q == $past(len_q) - ONE));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr_addr && !wr_len) |=> ($stable(addr_q) && $stable(len_q)));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_len && step) |=> (len_q == $past(wval)));

endmodule

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
    import dmac_pkg::*;
#(
    parameter bit CHAIN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_stat,
    input  logic             wr_mode,
    input  logic [REG_W-1:0] wdata,
    input  logic             last,
    output ctrl_t            ctrl_q,
    output mode_t            mode_q,
    output stat_t            stat_q,
    output logic             reload,
    output logic             irq_tc,
    output logic             irq_ovr
);
    logic ovr_ev, stop_ev;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[REG_W-1:7], wdata[5], wdata[3]};

    assign reload  = CHAIN && last && (mode_q.auto_init || ctrl_q.valid);
    assign stop_ev = last && !reload;
    assign ovr_ev  = CHAIN && stop_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            stat_q  <= '0;
            irq_tc  <= 1'b0;
            irq_ovr <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.enable <= wdata[0];
                ctrl_q.valid  <= CHAIN && wdata[1];
            end else begin
                if (stop_ev) ctrl_q.enable <= 1'b0;
                if (reload && !mode_q.auto_init) ctrl_q.valid <= 1'b0;
            end

            if (wr_mode) mode_q <= mode_t'(wdata[2:0]);

            stat_q.tc  <= (stat_q.tc  & ~(wr_stat & wdata[0])) | last;
            stat_q.ovr <= (stat_q.ovr & ~(wr_stat & wdata[2])) | ovr_ev;
            if (wr_stat) begin
                stat_q.tc_ie  <= wdata[4];
                stat_q.ovr_ie <= wdata[6];
            end

            irq_tc  <= last   && stat_q.tc_ie;
            irq_ovr <= ovr_ev && stat_q.ovr_ie;
        end
    end

    a_r3_irq_flag: assert property (@(posedge clk) disable iff (rst)
        irq_tc |-> stat_q.tc);

    a_r5_ovr_stop: assert property (@(posedge clk) disable iff (rst)
        (ovr_ev && !wr_ctrl) |=> (!ctrl_q.enable && stat_q.ovr));

    a_r4_chain_keep: assert property (@(posedge clk) disable iff (rst)
        (reload && !mode_q.auto_init && !wr_ctrl) |=> (ctrl_q.enable && !ctrl_q.valid));

    a_r8_sticky_tc: assert property (@(posedge clk) disable iff (rst)
        (stat_q.tc && !(wr_stat && wdata[0])) |=> stat_q.tc);

    a_r12_ovr_flag: assert property (@(posedge clk) disable iff (rst)
        irq_ovr |-> stat_q.ovr);

endmodule

// File: rtl/dma_chain_chan.sv
`timescale 1ns/1ps
module dma_chain_chan
    import dmac_pkg::*;
#(
    parameter int AW    = 24,
    parameter bit CHAIN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             xfer_done,
    output logic             chan_active,
    output logic             irq_tc,
    output logic             irq_ovr
);
    reg_sel_e      sel;
    logic          wr_ctrl, wr_stat, wr_mode, wr_addr, wr_len, wr_naddr, wr_nlen;
    logic          step, last, reload;
    ctrl_t         ctrl_q;
    mode_t         mode_q;
    stat_t         stat_q;
    logic [AW-1:0] addr_q, len_q, naddr_q, nlen_q;
    logic          unused_hi;

    assign unused_hi = ^bus_wdata[REG_W-1:AW];

    assign sel      = reg_sel_e'(bus_addr);
    assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
    assign wr_stat  = bus_wr && (sel == SEL_STAT);
    assign wr_mode  = bus_wr && (sel == SEL_MODE);
    assign wr_addr  = bus_wr && (sel == SEL_ADDR);
    assign wr_len   = bus_wr && (sel == SEL_LEN);
    assign wr_naddr = bus_wr && (sel == SEL_NADDR);
    assign wr_nlen  = bus_wr && (sel == SEL_NLEN);

    assign chan_active = ctrl_q.enable && (len_q != '0);
    assign step        = xfer_done && chan_active;

    dmac_counters #(.AW(AW), .CHAIN(CHAIN)) u_cnt (
        .clk(clk), .rst(rst), .step(step), .reload(reload), .mode(mode_q),
        .wr_addr(wr_addr), .wr_len(wr_len), .wr_naddr(wr_naddr), .wr_nlen(wr_nlen),
        .wval(bus_wdata[AW-1:0]),
        .addr_q(addr_q), .len_q(len_q), .naddr_q(naddr_q), .nlen_q(nlen_q),
        .last(last)
    );

    dmac_regs #(.CHAIN(CHAIN)) u_regs (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_mode(wr_mode),
        .wdata(bus_wdata), .last(last),
        .ctrl_q(ctrl_q), .mode_q(mode_q), .stat_q(stat_q),
        .reload(reload), .irq_tc(irq_tc), .irq_ovr(irq_ovr)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL:  bus_rdata = pack_ctrl(ctrl_q);
            SEL_STAT:  bus_rdata = pack_stat(stat_q, chan_active);
            SEL_MODE:  bus_rdata = pack_mode(mode_q);
            SEL_ADDR:  bus_rdata = REG_W'(addr_q);
            SEL_LEN:   bus_rdata = REG_W'(len_q);
            SEL_NADDR: bus_rdata = REG_W'(naddr_q);
            SEL_NLEN:  bus_rdata = REG_W'(nlen_q);
            SEL_NONE:  bus_rdata = '0;
        endcase
    end

    a_r7_active_len: assert property (@(posedge clk) disable iff (rst)
        (len_q == '0) |-> !chan_active);

    a_r9_no_step_idle: assert property (@(posedge clk) disable iff (rst)
        (!chan_active && !bus_wr) |=> !$rose(stat_q.tc));

endmodule

// File: tb/dma_chain_chan_test.sv
`timescale 1ns/1ps
module dma_chain_chan_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic        xfer_done = 1'b0;
    logic [31:0] bus_rdata;
    logic        chan_active, irq_tc, irq_ovr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_count = 0;

    always #2.5 clk = ~clk;

    dma_chain_chan uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_done(xfer_done),
        .chan_active(chan_active), .irq_tc(irq_tc), .irq_ovr(irq_ovr)
    );

    // behavioural reference state
    logic [23:0] m_addr, m_len, m_na, m_nl;
    bit m_en, m_vld, m_tc, m_ovr, m_tcie, m_ovie, m_step, m_down, m_auto;
    bit m_irqt, m_irqo;

    function automatic bit m_act();
        return m_en && (m_len != 24'd0);
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return {30'd0, m_vld, m_en};
            3'd1: return {25'd0, m_ovie, 1'b0, m_tcie, m_act(), m_ovr, 1'b0, m_tc};
            3'd2: return {29'd0, m_auto, m_down, m_step};
            3'd3: return {8'd0, m_addr};
            3'd4: return {8'd0, m_len};
            3'd5: return {8'd0, m_na};
            3'd6: return {8'd0, m_nl};
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_reset();
        m_addr = 0; m_len = 0; m_na = 0; m_nl = 0;
        m_en = 0; m_vld = 0; m_tc = 0; m_ovr = 0; m_tcie = 0; m_ovie = 0;
        m_step = 0; m_down = 0; m_auto = 0; m_irqt = 0; m_irqo = 0;
    endtask

    task automatic m_cycle(bit w, logic [2:0] a, logic [31:0] d, bit x);
        bit acc, fin, again;
        logic [23:0] na, nl;
        bit en, vld, tc, ovr;
        acc = x && m_act();
        fin = acc && (m_len == 24'd1);
        again = fin && (m_auto || m_vld);
        na = m_addr; nl = m_len; en = m_en; vld = m_vld;
        if (acc) begin
            if (again) begin
                na = m_na; nl = m_nl;
            end else begin
                if (m_step) na = m_down ? m_addr - 24'd1 : m_addr + 24'd1;
                nl = m_len - 24'd1;
            end
        end
        if (fin && !again) en = 0;
        if (again && !m_auto) vld = 0;
        tc = m_tc; ovr = m_ovr;
        if (w && a == 3'd1) begin
            if (d[0]) tc = 0;
            if (d[2]) ovr = 0;
        end
        if (fin) tc = 1;
        if (fin && !again) ovr = 1;
        m_irqt = fin && m_tcie;
        m_irqo = fin && !again && m_ovie;
        if (w) begin
            case (a)
                3'd0: begin en = d[0]; vld = d[1]; end
                3'd1: begin m_tcie = d[4]; m_ovie = d[6]; end
                3'd2: begin m_step = d[0]; m_down = d[1]; m_auto = d[2]; end
                3'd3: na = d[23:0];
                3'd4: nl = d[23:0];
                3'd5: m_na = d[23:0];
                3'd6: m_nl = d[23:0];
                default: ;
            endcase
        end
        m_addr = na; m_len = nl; m_en = en; m_vld = vld; m_tc = tc; m_ovr = ovr;
    endtask

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp, string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at t=%0t: actual %h expected %h", tag, what, $time, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        cmp("rdata", bus_rdata, m_read(bus_addr), tag);
        cmp("chan_active", {31'd0, chan_active}, {31'd0, m_act()}, tag);
        cmp("irq_tc", {31'd0, irq_tc}, {31'd0, m_irqt}, tag);
        cmp("irq_ovr", {31'd0, irq_ovr}, {31'd0, m_irqo}, tag);
    endtask

    task automatic cyc(bit w, logic [2:0] a, logic [31:0] d, bit x, string tag);
        bus_wr = w; bus_addr = a; bus_wdata = d; xfer_done = x;
        m_cycle(w, a, d, x);
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
        cyc(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic rd(logic [2:0] a, string tag);
        cyc(1'b0, a, 32'd0, 1'b0, tag);
    endtask

    task automatic xf(logic [2:0] a, string tag);
        cyc(1'b0, a, 32'd0, 1'b1, tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc_count);
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        m_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            check_all("R10");
        end
        rst = 1'b0;
        for (int i = 0; i < 8; i++) rd(3'(i), "R10");

        // reserved upper bits, wrap of the up counter
        wr(3'd3, 32'hFFFF_FFFE, "R1");
        wr(3'd4, 32'hAB00_0004, "R1");
        wr(3'd5, 32'hCD12_3456, "R1");
        rd(3'd3, "R1"); rd(3'd4, "R1"); rd(3'd5, "R1"); rd(3'd7, "R1");
        wr(3'd2, 32'h1, "R2");
        wr(3'd1, 32'h50, "R3");
        wr(3'd0, 32'h1, "R7");
        rd(3'd1, "R7");
        xf(3'd3, "R2"); xf(3'd3, "R2");
        rd(3'd4, "R3");
        xf(3'd3, "R2");
        xf(3'd1, "R5");
        rd(3'd1, "R12");
        rd(3'd0, "R5");
        // strobes with the channel stopped
        xf(3'd3, "R9"); xf(3'd4, "R9"); xf(3'd1, "R9");

        // independent write-1-to-clear, active bit not writable
        wr(3'd1, 32'h54, "R8");
        rd(3'd1, "R8");
        wr(3'd1, 32'h5D, "R8");
        rd(3'd1, "R7");

        // chained block, counting down
        wr(3'd2, 32'h3, "R2");
        wr(3'd3, 32'h100, "R4");
        wr(3'd4, 32'h2, "R4");
        wr(3'd5, 32'h800, "R4");
        wr(3'd6, 32'h3, "R4");
        wr(3'd0, 32'h3, "R4");
        xf(3'd3, "R2");
        xf(3'd3, "R4");
        rd(3'd0, "R4"); rd(3'd4, "R4"); rd(3'd1, "R4");
        xf(3'd3, "R2"); xf(3'd4, "R3"); xf(3'd0, "R5");
        rd(3'd1, "R5");

        // auto-initialise with hold addressing
        wr(3'd1, 32'h55, "R8");
        wr(3'd2, 32'h4, "R6");
        wr(3'd3, 32'h10, "R6");
        wr(3'd4, 32'h2, "R6");
        wr(3'd5, 32'h20, "R6");
        wr(3'd6, 32'h1, "R6");
        wr(3'd0, 32'h1, "R6");
        xf(3'd3, "R2"); xf(3'd3, "R6");
        xf(3'd4, "R6"); xf(3'd1, "R6");
        rd(3'd0, "R6");
        wr(3'd0, 32'h0, "R7");
        rd(3'd1, "R7");

        // set and clear in the same cycle
        wr(3'd2, 32'h0, "R8");
        wr(3'd4, 32'h1, "R8");
        wr(3'd0, 32'h1, "R8");
        cyc(1'b1, 3'd1, 32'h55, 1'b1, "R8");
        rd(3'd1, "R8");

        // counter write beats strobe
        wr(3'd4, 32'h5, "R11");
        wr(3'd0, 32'h1, "R11");
        cyc(1'b1, 3'd4, 32'h9, 1'b1, "R11");
        rd(3'd4, "R11");
        cyc(1'b1, 3'd3, 32'h77, 1'b1, "R11");
        rd(3'd3, "R11");

        // mixed traffic
        r = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            bit w;
            logic [2:0] a;
            logic [31:0] d;
            r = r * 32'd1103515245 + 32'd12345;
            w = (r[20:18] == 3'd0);
            a = r[23:21];
            d = {r[15:0], r[31:16]};
            if (a == 3'd4 || a == 3'd6) d = {8'hA5, 21'd0, 3'(r[26:25]) + 3'd1};
            cyc(w, a, d, r[16] | r[17], "R3");
        end
        for (int i = 0; i < 8; i++) rd(3'(i), "R12");

        finish_run();
    end

endmodule